// File: doc/BRIEF.md
# Crystal Oscillator Warm-up Qualifier

This block decides when a newly started crystal oscillator may drive the system clock. It runs on the crystal's own clock. Each time the crystal has to settle it counts a fixed number of crystal cycles, 65,536 by default, before it lets the clock switch go ahead. There are three reasons to settle: the block leaves its power-up reset, the chip leaves stop mode, or the crystal frequency multiplier is switched on. This count has nothing to do with the programmable watchdog interval counter.

There are two qualification outputs. One says the plain crystal clock may be selected. The other says the multiplied clock may be selected. While the multiplier settles, the plain crystal path stays qualified, so the clock mux can keep using it. Both flags are produced in the crystal domain. Each one then passes through a two-stage synchronizer into the system clock domain, where the clock-selection logic reads it.

Top module: `osc_warmup_gate`

## Requirements
- R1: Once `xtal_rst_n` is released, `xtal_ok` stays low for as long as fewer than WARM_CYCLES crystal cycles have passed. The crystal-domain flag rises on exactly the WARM_CYCLES-th crystal rising edge after the trigger, and `xtal_ok` follows through the synchronizer.
- R2: A crystal edge that samples `stop_exit` high clears both the crystal flag and the multiplier flag. It also starts a new full count.
- R3: A trigger that arrives while a count is running restarts the count from zero. Readiness then needs a full WARM_CYCLES interval after the last trigger.
- R4: A rising edge on `mult_en` restarts the count and clears only the multiplier flag. If the crystal flag was already high, it stays high.
- R5: The multiplier flag can be high only while `mult_en` is high and the crystal flag is high. A crystal edge that samples `mult_en` low clears it.
- R6: Each flag reaches the system domain through two flops clocked by `sys_clk`. While `sys_rst_n` is low, both `xtal_ok` and `mult_ok` are held low.
- R7: While `xtal_rst_n` is low, both crystal-domain flags are low and the counter is held at zero, ready to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal oscillator clock; the counter runs on it |
| xtal_rst_n | input | 1 | Active-low asynchronous power-up reset, crystal domain |
| stop_exit | input | 1 | High for one or more crystal cycles when the crystal restarts after stop mode |
| mult_en | input | 1 | Level request for the frequency multiplier; a rising edge triggers a warm-up |
| sys_clk | input | 1 | System clock, destination domain of the flags |
| sys_rst_n | input | 1 | Active-low asynchronous reset of the synchronizers |
| xtal_ok | output | 1 | Plain crystal clock may be selected (system domain) |
| mult_ok | output | 1 | Multiplied clock may be selected (system domain) |

## Verification
The bench starts with a count that runs undisturbed from reset and checks the outputs just before and just after the terminal edge. This tells a correct terminal count apart from one that is off by a few cycles. A second stop exit arrives midway through a count. The check falls at a point where the time since the first trigger has passed the interval but the time since the second has not, so the outcome shows whether the count restarted or kept running. The multiplier is raised while the crystal is already qualified and also during a stop-exit warm-up, and later dropped. This separates a design that keeps the crystal flag independent from one that clears both flags on every trigger. A system-domain reset in the middle of the run checks the synchronizer path on its own.

// File: rtl/osc_warmup_pkg.sv
package osc_warmup_pkg;

  typedef struct packed {
    logic stop;     // crystal restarted after stop mode
    logic mult_up;  // multiplier request just asserted
  } wu_trig_t;

  function automatic int count_bits(input int warm);
    return (warm <= 2) ? 1 : $clog2(warm);
  endfunction

  function automatic logic at_terminal(input logic [31:0] cnt, input int warm);
    return cnt == 32'(warm - 1);
  endfunction

endpackage

// File: rtl/osc_warmup_trig.sv
module osc_warmup_trig
  import osc_warmup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stop_exit,
  input  logic     mult_en,
  output wu_trig_t trig,
  output logic     restart
);
  logic mult_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mult_q <= 1'b0;
    else        mult_q <= mult_en;
  end

  always_comb begin
    trig.stop    = stop_exit;
    trig.mult_up = mult_en & ~mult_q;
    restart      = trig.stop | trig.mult_up;
  end
endmodule

// File: rtl/osc_warmup_count.sv
module osc_warmup_count
  import osc_warmup_pkg::*;
#(
  parameter int WARM_CYCLES = 65536,
  localparam int CW = count_bits(WARM_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);
  assign done = busy & ~restart & at_terminal(32'(cnt), WARM_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (restart) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/osc_warmup_flags.sv
module osc_warmup_flags
  import osc_warmup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wu_trig_t trig,
  input  logic     done,
  input  logic     mult_en,
  output logic     xtal_rdy,
  output logic     mult_rdy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_rdy <= 1'b0;
      mult_rdy <= 1'b0;
    end else begin
      if (trig.stop)  xtal_rdy <= 1'b0;
      else if (done)  xtal_rdy <= 1'b1;

      if (trig.stop || trig.mult_up || !mult_en) mult_rdy <= 1'b0;
      else if (done)                             mult_rdy <= 1'b1;
    end
  end
endmodule

// File: rtl/osc_warmup_sync.sv
module osc_warmup_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else             stage[s] <= stage[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/osc_warmup_gate.sv
module osc_warmup_gate
  import osc_warmup_pkg::*;
#(
  parameter int WARM_CYCLES = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic xtal_clk,
  input  logic xtal_rst_n,
  input  logic stop_exit,
  input  logic mult_en,
  input  logic sys_clk,
  input  logic sys_rst_n,
  output logic xtal_ok,
  output logic mult_ok
);
  localparam int CW = count_bits(WARM_CYCLES);

  wu_trig_t      trig;
  logic          any_restart;
  logic          busy;
  logic [CW-1:0] cnt;
  logic          done;
  logic          xtal_rdy;
  logic          mult_rdy;
  logic          stop_trig;
  logic          mult_rise;
  logic [1:0]    sync_q;

  assign stop_trig = trig.stop;
  assign mult_rise = trig.mult_up;

  osc_warmup_trig u_trig (
    .clk(xtal_clk), .rst_n(xtal_rst_n), .stop_exit(stop_exit),
    .mult_en(mult_en), .trig(trig), .restart(any_restart)
  );

  osc_warmup_count #(.WARM_CYCLES(WARM_CYCLES)) u_count (
    .clk(xtal_clk), .rst_n(xtal_rst_n), .restart(any_restart),
    .busy(busy), .cnt(cnt), .done(done)
  );

  osc_warmup_flags u_flags (
    .clk(xtal_clk), .rst_n(xtal_rst_n), .trig(trig), .done(done),
    .mult_en(mult_en), .xtal_rdy(xtal_rdy), .mult_rdy(mult_rdy)
  );

  osc_warmup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d({mult_rdy, xtal_rdy}), .q(sync_q)
  );

  assign xtal_ok = sync_q[0];
  assign mult_ok = sync_q[1];
endmodule

// File: rtl/osc_warmup_gate_chk.sv
module osc_warmup_gate_chk #(
  parameter int WARM_CYCLES = 65536,
  parameter int CW = 16
) (
  input logic          xtal_clk,
  input logic          xtal_rst_n,
  input logic          stop_trig,
  input logic          mult_rise,
  input logic          any_restart,
  input logic          mult_en,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic          xtal_rdy,
  input logic          mult_rdy
);
  assert_ready_at_end_R1: assert property (@(posedge xtal_clk) disable iff (!xtal_rst_n)
    $fell(busy) |-> xtal_rdy);

  assert_rise_only_at_end_R1: assert property (@(posedge xtal_clk) disable iff (!xtal_rst_n)
    $rose(xtal_rdy) |-> $fell(busy));

  assert_stop_clears_R2: assert property (@(posedge xtal_clk) disable iff (!xtal_rst_n)
    stop_trig |=> (!xtal_rdy && !mult_rdy && busy));

  assert_restart_zero_R3: assert property (@(posedge xtal_clk) disable iff (!xtal_rst_n)
    any_restart |=> (busy && cnt == '0));

  assert_mult_keeps_xtal_R4: assert property (@(posedge xtal_clk) disable iff (!xtal_rst_n)
    (mult_rise && !stop_trig && xtal_rdy) |=> (xtal_rdy && !mult_rdy));

  assert_mult_needs_xtal_R5: assert property (@(posedge xtal_clk) disable iff (!xtal_rst_n)
    mult_rdy |-> xtal_rdy);

  assert_mult_drop_R5: assert property (@(posedge xtal_clk) disable iff (!xtal_rst_n)
    !mult_en |=> !mult_rdy);
endmodule

bind osc_warmup_gate osc_warmup_gate_chk #(.WARM_CYCLES(WARM_CYCLES), .CW(CW)) u_chk (
  .xtal_clk(xtal_clk), .xtal_rst_n(xtal_rst_n), .stop_trig(stop_trig),
  .mult_rise(mult_rise), .any_restart(any_restart), .mult_en(mult_en),
  .busy(busy), .cnt(cnt), .xtal_rdy(xtal_rdy), .mult_rdy(mult_rdy)
);

// File: tb/sim_osc_warmup_gate.sv
`timescale 1ns/1ps
module sim_osc_warmup_gate;
  localparam int W = 64;
  localparam int N = 8;
  // event codes: 0 none, 1 stop-exit pulse, 2 raise mult_en, 3 drop mult_en
  localparam int EV  [N] = '{1, 0, 2, 0, 1, 1, 0, 3};
  localparam int WT  [N] = '{W/2, W, W/2, W, W/2, W-4, 8, 2};
  localparam bit EXX [N] = '{0, 1, 1, 1, 0, 0, 1, 1};
  localparam bit EXM [N] = '{0, 0, 0, 1, 0, 0, 1, 0};
  localparam string RQ [N] = '{"R2", "R1", "R4", "R4", "R2", "R3", "R3", "R5"};

  logic xclk = 0, sclk = 0;
  logic xrst_n = 0, srst_n = 0, stop_exit = 0, mult_en = 0;
  logic xtal_ok, mult_ok;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #6   xclk = ~xclk;
  always #2.5 sclk = ~sclk;

  osc_warmup_gate #(.WARM_CYCLES(W)) u0 (
    .xtal_clk(xclk), .xtal_rst_n(xrst_n), .stop_exit(stop_exit), .mult_en(mult_en),
    .sys_clk(sclk), .sys_rst_n(srst_n), .xtal_ok(xtal_ok), .mult_ok(mult_ok)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic xwait(input int n);
    repeat (n) @(posedge xclk);
  endtask

  task automatic settle();
    repeat (4) @(posedge sclk);
    #1;
  endtask

  task automatic apply(input int ev);
    @(negedge xclk);
    case (ev)
      1: begin stop_exit = 1; @(negedge xclk); stop_exit = 0; end
      2: mult_en = 1;
      3: mult_en = 0;
      default: ;
    endcase
  endtask

  task automatic both(input string req, input logic ex, input logic em);
    chk(req, "xtal_ok", xtal_ok, ex);
    chk(req, "mult_ok", mult_ok, em);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    xwait(3);
    #1;
    both("R7", 1'b0, 1'b0);
    @(negedge xclk);
    srst_n = 1;
    xrst_n = 1;
    // R1: not ready two cycles before the terminal edge, ready after it
    xwait(W - 3);
    settle();
    both("R1", 1'b0, 1'b0);
    xwait(6);
    settle();
    both("R1", 1'b1, 1'b0);

    for (int i = 0; i < N; i++) begin
      apply(EV[i]);
      xwait(WT[i]);
      settle();
      both(RQ[i], EXX[i], EXM[i]);
    end

    // R6: system-domain reset forces outputs low, then they resync
    @(negedge sclk);
    srst_n = 0;
    #1;
    both("R6", 1'b0, 1'b0);
    @(negedge sclk);
    srst_n = 1;
    @(posedge sclk); #1;
    chk("R6", "xtal_ok one stage", xtal_ok, 1'b0);
    @(posedge sclk); #1;
    chk("R6", "xtal_ok two stages", xtal_ok, 1'b1);

    // R3/R4: multiplier raised during a stop-exit warm-up restarts the count
    apply(1);
    xwait(4);
    apply(2);
    xwait(W - 4);
    settle();
    both("R3", 1'b0, 1'b0);
    xwait(8);
    settle();
    both("R4", 1'b1, 1'b1);

    // R7: power-up reset clears both flags
    @(negedge xclk);
    xrst_n = 0;
    settle();
    both("R7", 1'b0, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule